// File: doc/BRIEF.md
# Pull Resistor Latch Sequencer

This block keeps the pull-resistor setting of a set of pads: pull-up, pull-down or neither, one setting per pin. Software loads the setting in two steps. First it writes a two-bit pull code into one shared control register. Then it raises bits in a per-bank strobe register. Each raised bit selects one pin. After the strobe has stayed high for a set number of timing ticks, every selected pin copies the current code.

The block also enforces the timing between the two steps. A strobe bit raised before enough ticks have passed since the last control write is refused, and a sticky timing-error flag is set. Ticks come from a slow reference pulse on `tick_i`, not from the system clock. The latched per-pin settings cannot be read back over the bus. They are visible only as the two pull-enable outputs of each pin.

Pin p is in bank p / BANK_W, at bit p % BANK_W. The strobe register of bank b is at byte address STB_BASE + 4*b. The control register is at CTRL_ADDR. Both defaults come from a 54-pin, 32-bit-bank layout.

Top module: `pull_latch_seq`

## Requirements
- R1: After reset, every pull_up_o and pull_dn_o bit is 0 and timing_err_o is 0.
- R2: A latch of code 0 drives both pull outputs of the pin low. Code 1 drives pull_dn_o high and pull_up_o low. Code 2 drives pull_up_o high and pull_dn_o low. The two outputs of one pin are never both high.
- R3: A latch of code 3 leaves the pin's pull outputs as they were.
- R4: A pin latches only after its strobe bit has been high for HOLD_TICKS ticks since the last write to its bank register. With fewer ticks, the outputs do not change.
- R5: If a strobe bit goes from 0 to 1 while fewer than SETUP_TICKS ticks have passed since the last control write (reset counts as one), timing_err_o is set and that pin latches nothing.
- R6: Once set, timing_err_o stays high until reset, through later valid sequences.
- R7: A latch changes only the pins whose strobe bits were set: bit p % BANK_W of bank p / BANK_W. All other pins keep their outputs.
- R8: Only data bits [1:0] of a control write are used. Writes to addresses other than the control register and the NUM_BANKS strobe registers have no effect on the outputs.
- R9: Writing a strobe bit back to 0 before the hold count ends cancels that pin's latch.
- R10: Only cycles with tick_i high advance the setup and hold counts. Idle cycles without a tick do not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing reference pulse, one cycle wide |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | BANK_W | Register write data |
| pull_up_o | output | NUM_PINS | Pull-up enable per pin |
| pull_dn_o | output | NUM_PINS | Pull-down enable per pin |
| timing_err_o | output | 1 | Sticky setup-violation flag |

## Verification
The bench builds the block with 10 pins in banks of 4, a setup count of 3 and a hold count of 2. With these values the last bank holds only two pins, so the ragged upper bank is exercised. Every pin can be swept through all four codes, and the exact tick on which setup is met or hold completes can be hit on both sides of the boundary. A model in the bench predicts all pin outputs after each sequence. The sweep covers single pins, several bank-wide masks, two banks strobed together, a canceled strobe and a setup violation.

// File: rtl/pull_seq_pkg.sv
package pull_seq_pkg;
  typedef enum logic [1:0] {
    PULL_OFF  = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_BAD  = 2'd3
  } pull_code_e;
endpackage

// File: rtl/pull_setup_timer.sv
module pull_setup_timer #(
  parameter int SETUP_TICKS = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic ready_o
);
  localparam int CW = $clog2(SETUP_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETUP_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (restart_i)                cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIMIT);
endmodule

// File: rtl/pull_bank_seq.sv
module pull_bank_seq #(
  parameter int WIDTH      = 32,
  parameter int HOLD_TICKS = 150
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             setup_ok_i,
  input  logic             tick_i,
  output logic [WIDTH-1:0] latch_o,
  output logic             viol_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HLIM = HW'(HOLD_TICKS);

  logic [WIDTH-1:0] stb_q, armed_q, rising;
  logic [HW-1:0]    hold_q;
  logic             fire;

  assign rising  = wdata_i & ~stb_q;
  assign viol_o  = wr_i && (|rising) && !setup_ok_i;
  assign fire    = !wr_i && (|armed_q) && (hold_q == HLIM);
  assign latch_o = fire ? armed_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q   <= '0;
      armed_q <= '0;
      hold_q  <= '0;
    end else if (wr_i) begin
      stb_q   <= wdata_i;
      // bits already armed stay armed; new bits arm only with setup met
      armed_q <= wdata_i & (armed_q | (setup_ok_i ? rising : '0));
      hold_q  <= '0;
    end else if (fire) begin
      armed_q <= '0;
    end else if (tick_i && (|armed_q) && hold_q != HLIM) begin
      hold_q  <= hold_q + 1'b1;
    end
  end
endmodule

// File: rtl/pull_cfg_store.sv
module pull_cfg_store
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS = 54
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] latch_i,
  input  pull_code_e          code_i,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_dn_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pull_up_o[p] <= 1'b0;
        pull_dn_o[p] <= 1'b0;
      end else if (latch_i[p] && code_i != PULL_BAD) begin
        pull_up_o[p] <= (code_i == PULL_UP);
        pull_dn_o[p] <= (code_i == PULL_DOWN);
      end
    end
  end
endmodule

// File: rtl/pull_latch_seq.sv
module pull_latch_seq
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS    = 54,
  parameter int BANK_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int CTRL_ADDR   = 'h94,
  parameter int STB_BASE    = 'h98,
  parameter int SETUP_TICKS = 150,
  parameter int HOLD_TICKS  = 150
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [BANK_W-1:0]   bus_wdata_i,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_dn_o,
  output logic                timing_err_o
);
  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

  pull_code_e            code_q;
  logic                  ctrl_wr, setup_ok;
  logic [NUM_BANKS-1:0]  bank_viol;
  logic [NUM_PINS-1:0]   latch_pins;

  assign ctrl_wr = bus_we_i && (bus_addr_i == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= PULL_OFF;
    else if (ctrl_wr) code_q <= pull_code_e'(bus_wdata_i[1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          timing_err_o <= 1'b0;
    else if (|bank_viol)  timing_err_o <= 1'b1;
  end

  pull_setup_timer #(.SETUP_TICKS(SETUP_TICKS)) u_setup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (ctrl_wr),
    .tick_i    (tick_i),
    .ready_o   (setup_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    localparam int W  = (NUM_PINS - LO < BANK_W) ? (NUM_PINS - LO) : BANK_W;
    logic bank_wr;
    assign bank_wr = bus_we_i && (bus_addr_i == ADDR_W'(STB_BASE + 4 * b));

    pull_bank_seq #(.WIDTH(W), .HOLD_TICKS(HOLD_TICKS)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (bank_wr),
      .wdata_i    (bus_wdata_i[W-1:0]),
      .setup_ok_i (setup_ok),
      .tick_i     (tick_i),
      .latch_o    (latch_pins[LO +: W]),
      .viol_o     (bank_viol[b])
    );
  end

  pull_cfg_store #(.NUM_PINS(NUM_PINS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .latch_i   (latch_pins),
    .code_i    (code_q),
    .pull_up_o (pull_up_o),
    .pull_dn_o (pull_dn_o)
  );
endmodule

// File: rtl/pull_latch_seq_chk.sv
module pull_latch_seq_chk
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS = 54
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_we_i,
  input logic                timing_err_o,
  input logic [NUM_PINS-1:0] pull_up_o,
  input logic [NUM_PINS-1:0] pull_dn_o,
  input logic [NUM_PINS-1:0] latch_pins,
  input pull_code_e          code_q
);
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_o & pull_dn_o) == '0); // R2

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_err_o |=> timing_err_o); // R6

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!timing_err_o && !bus_we_i) |=> !timing_err_o); // R5

  AST_NO_LATCH_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_pins == '0) |=> ($stable(pull_up_o) && $stable(pull_dn_o))); // R4

  AST_BAD_CODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == PULL_BAD) |=> ($stable(pull_up_o) && $stable(pull_dn_o))); // R3

  AST_UNSELECTED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((pull_up_o ^ $past(pull_up_o)) | (pull_dn_o ^ $past(pull_dn_o)))
              & ~$past(latch_pins)) == '0); // R7
endmodule

bind pull_latch_seq pull_latch_seq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_we_i     (bus_we_i),
  .timing_err_o (timing_err_o),
  .pull_up_o    (pull_up_o),
  .pull_dn_o    (pull_dn_o),
  .latch_pins   (latch_pins),
  .code_q       (code_q)
);

// File: tb/pull_latch_seq_bench.sv
module pull_latch_seq_bench;
  localparam int NP = 10;
  localparam int BW = 4;
  localparam int ST = 3;
  localparam int HT = 2;
  localparam logic [7:0] CTRL = 8'h94;
  localparam int WD_CYCLES = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [BW-1:0] wdata = '0;
  logic [NP-1:0] pu, pd;
  logic          err;

  logic [NP-1:0] exp_up = '0, exp_dn = '0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pull_latch_seq #(
    .NUM_PINS(NP), .BANK_W(BW), .ADDR_W(8), .CTRL_ADDR('h94), .STB_BASE('h98),
    .SETUP_TICKS(ST), .HOLD_TICKS(HT)
  ) u_pull_latch_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata),
    .pull_up_o(pu), .pull_dn_o(pd), .timing_err_o(err)
  );

  function automatic logic [7:0] stb_addr(int b);
    return 8'(8'h98 + 4 * b);
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [BW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic model(logic [1:0] code, int bank, logic [BW-1:0] mask);
    for (int i = 0; i < BW; i++) begin
      int p = bank * BW + i;
      if (mask[i] && p < NP && code != 2'd3) begin
        exp_up[p] = (code == 2'd2);
        exp_dn[p] = (code == 2'd1);
      end
    end
  endtask

  task automatic chk_pulls(string tag);
    checks++;
    if (pu !== exp_up || pd !== exp_dn) begin
      fails++;
      $display("FAIL %s up=%b dn=%b expected up=%b dn=%b", tag, pu, pd, exp_up, exp_dn);
    end
  endtask

  task automatic chk_err(string tag, logic e);
    checks++;
    if (err !== e) begin
      fails++;
      $display("FAIL %s err=%b expected %b", tag, err, e);
    end
  endtask

  // full valid sequence on one bank
  task automatic seq(logic [BW-1:0] ctrl_d, int bank, logic [BW-1:0] mask);
    wr(CTRL, ctrl_d);
    ticks(ST);
    wr(stb_addr(bank), mask);
    ticks(HT);
    idle(2);
    wr(stb_addr(bank), '0);
    model(ctrl_d[1:0], bank, mask);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk_pulls("R1 reset pulls");
    chk_err("R1 reset err", 1'b0);

    // R2 R3 R7: every pin through every code
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [1:0] c = (k == 0) ? 2'd1 : (k == 1) ? 2'd2 : (k == 2) ? 2'd3 : 2'd0;
        if (k == 3) seq(BW'(2'd2), p / BW, BW'(1) << (p % BW));
        seq(BW'(c), p / BW, BW'(1) << (p % BW));
        chk_pulls(c == 2'd3 ? "R3 code3 unchanged" : "R2 R7 code map sweep");
      end
    end

    // R7: bank masks incl. ragged top bank, two banks at once
    seq(BW'(2'd1), 2, '1);
    chk_pulls("R7 ragged bank");
    seq(BW'(2'd2), 1, 4'b1010);
    chk_pulls("R7 bank mask");
    wr(CTRL, BW'(2'd1));
    ticks(ST);
    wr(stb_addr(1), 4'b0101);
    wr(stb_addr(0), 4'b0011);
    ticks(HT);
    idle(2);
    wr(stb_addr(1), '0);
    wr(stb_addr(0), '0);
    model(2'd1, 1, 4'b0101);
    model(2'd1, 0, 4'b0011);
    chk_pulls("R7 two banks");

    // R4 R10: hold boundary and idle time without ticks
    wr(CTRL, BW'(2'd2));
    ticks(ST);
    wr(stb_addr(0), 4'b0100);
    ticks(HT - 1);
    idle(25);
    chk_pulls("R4 R10 hold short");
    ticks(1);
    idle(2);
    model(2'd2, 0, 4'b0100);
    chk_pulls("R4 hold met");
    wr(stb_addr(0), '0);

    // R10: idle cycles do not count toward setup
    wr(CTRL, BW'(2'd0));
    ticks(ST - 1);
    idle(25);
    chk_err("R10 setup idle before", 1'b0);
    wr(stb_addr(0), 4'b0100);
    chk_err("R10 setup short by idle", 1'b1);
    wr(stb_addr(0), '0);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    exp_up = '0; exp_dn = '0;
    chk_pulls("R1 reset again");
    chk_err("R1 err cleared", 1'b0);
    seq(BW'(2'd2), 0, 4'b1111);
    seq(BW'(2'd1), 2, 4'b0011);

    // R9: cancel before hold completes
    wr(CTRL, BW'(2'd0));
    ticks(ST);
    wr(stb_addr(0), 4'b1111);
    ticks(HT - 1);
    wr(stb_addr(0), '0);
    ticks(HT + 2);
    idle(2);
    chk_pulls("R9 cancel");

    // R8: high data bits dropped, stray addresses ignored
    seq(4'b1101, 1, 4'b0001);
    chk_pulls("R8 high bits ignored");
    wr(CTRL, BW'(2'd0));
    ticks(ST);
    wr(8'hA4, '1);
    wr(8'h90, '1);
    wr(8'h95, '1);
    ticks(HT + 2);
    idle(2);
    chk_pulls("R8 stray address");

    // R5 R6: setup violation
    chk_err("R5 no error yet", 1'b0);
    wr(CTRL, BW'(2'd2));
    ticks(ST - 1);
    wr(stb_addr(2), 4'b0001);
    chk_err("R5 violation flag", 1'b1);
    ticks(HT + 3);
    idle(2);
    chk_pulls("R5 nothing latched");
    wr(stb_addr(2), '0);
    seq(BW'(2'd1), 1, 4'b0110);
    chk_pulls("R6 valid after error");
    chk_err("R6 sticky", 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WD_CYCLES; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule